// File: doc/BRIEF.md
# Pole-Dead Inhibited Up/Down Phase Comparator

This block is a counting phase comparator for one pole of a line protection scheme. Two squared signals, A and B, are compared by watching their transitions. Every transition on either input moves an up/down counter. When the counter climbs to an operate threshold, the operate flag goes high. A counter clamped at both ends gives the comparator a measure of how long it has seen coincidence.

The block also takes a voltage-present flag and a current-present flag for the pole. Upstream level detectors produce these flags, at roughly 70 % of rated voltage and roughly 5 % of rated current. When both flags drop, a timer starts. It sets a pole-dead flag after a fixed delay (nominally 20 ms, counted in clock cycles). While pole-dead is set, every transition on A or B is a down count whatever the coincidence. An operated comparator is therefore drained quickly to zero once the line goes dead. As soon as either flag returns, the timer and pole-dead clear.

Top module: `pdc_comparator`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the count is 0 and the operate and pole-dead flags are low.
- R2: When pole-dead is low, a single transition on A or B, after which A equals B, raises the count by one. The new count is visible after the clock edge that samples the transition.
- R3: When pole-dead is low, a single transition on A or B, after which A differs from B, lowers the count by one.
- R4: Transitions on A and B sampled at the same edge count as two steps. The direction is chosen by the same coincidence rule as R2 and R3, or both steps are down when pole-dead is high.
- R5: The count never exceeds COUNT_MAX. An up step at COUNT_MAX leaves it at COUNT_MAX.
- R6: The count never goes below zero. A down step at zero leaves it at zero.
- R7: The operate flag is high exactly when the count is at or above OP_THRESH.
- R8: Pole-dead rises at the clock edge where both presence flags have been low for DELAY consecutive samples, with DELAY = CLK_HZ * DEAD_MS / 1000.
- R9: If either presence flag is high at a clock edge, pole-dead is low after that edge and the delay timer restarts from zero. One flag alone being low never sets pole-dead.
- R10: While pole-dead is high, each transition on A and each transition on B lowers the count by one, whether or not the inputs coincide.
- R11: At an edge with no transition on A or B, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_a_i | input | 1 | Squared comparator input A |
| sig_b_i | input | 1 | Squared comparator input B |
| volt_ok_i | input | 1 | Pole voltage above its level setting |
| curr_ok_i | input | 1 | Pole current above its level setting |
| count_o | output | COUNT_W | Comparator counter value |
| operate_o | output | 1 | Comparator operated |
| pole_dead_o | output | 1 | Delayed pole-dead inhibit |

## Verification
Each input change is applied at a falling edge and sampled at the next rising edge. The count, the operate flag and the pole-dead flag all show the effect of that sample right after that single rising edge. The driver updates its reference model at the rising edge and queues the expected triple. The monitor compares the outputs at the following falling edge, half a period after they settle. The pole-dead rise is checked against the exact cycle count of the delay, and clearing is checked on the first edge after a flag returns.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    // number of comparator inputs watched for transitions
    localparam int unsigned NUM_SIG = 2;

    // per-cycle step count: 0..NUM_SIG
    typedef logic [1:0] step_t;

    // count of set bits in a small vector
    function automatic step_t count_ones(input logic [NUM_SIG-1:0] v);
        step_t n;
        n = '0;
        for (int i = 0; i < NUM_SIG; i++) begin
            n = n + step_t'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/pdc_edge_sense.sv
module pdc_edge_sense
    import pdc_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SIG-1:0] sig_i,
    output logic [NUM_SIG-1:0] edge_o,
    output logic               coincide_o
);

    typedef struct packed {
        logic [NUM_SIG-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_edge
        assign edge_o[g] = sig_i[g] ^ st_q.prev[g];
    end

    // coincidence judged on the values after the transition
    assign coincide_o = (sig_i[0] == sig_i[1]);

endmodule

// File: rtl/pdc_dead_timer.sv
module pdc_dead_timer #(
    parameter int unsigned CLK_HZ  = 1_000_000,
    parameter int unsigned DEAD_MS = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic volt_ok_i,
    input  logic curr_ok_i,
    output logic dead_o
);

    localparam int unsigned DELAY   = (CLK_HZ / 1000) * DEAD_MS;
    localparam int unsigned DELAY_W = $clog2(DELAY + 1);
    localparam logic [DELAY_W-1:0] LAST = DELAY_W'(DELAY - 1);

    typedef struct packed {
        logic [DELAY_W-1:0] tmr;
        logic               dead;
    } state_t;

    state_t st_d, st_q;
    logic   alive;

    assign alive = volt_ok_i | curr_ok_i;

    always_comb begin
        st_d = st_q;
        if (alive) begin
            st_d.tmr  = '0;
            st_d.dead = 1'b0;
        end else if (st_q.tmr == LAST) begin
            st_d.dead = 1'b1;
        end else begin
            st_d.tmr = st_q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign dead_o = st_q.dead;

    p_dead_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alive |=> !st_q.dead);

    p_dead_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.dead) |-> $past(!alive));

    p_timer_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.tmr <= LAST);

endmodule

// File: rtl/pdc_updown.sv
module pdc_updown
    import pdc_pkg::*;
#(
    parameter int unsigned COUNT_MAX = 16,
    parameter int unsigned OP_THRESH = 8,
    localparam int unsigned COUNT_W  = $clog2(COUNT_MAX + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  step_t              inc_i,
    input  step_t              dec_i,
    output logic [COUNT_W-1:0] count_o,
    output logic               operate_o
);

    typedef struct packed {
        logic [COUNT_W-1:0] cnt;
        logic               op;
    } state_t;

    state_t st_d, st_q;
    int     sum;

    always_comb begin
        st_d = st_q;
        sum  = int'(st_q.cnt) + int'(inc_i) - int'(dec_i);
        if (sum < 0)                   st_d.cnt = '0;
        else if (sum > int'(COUNT_MAX)) st_d.cnt = COUNT_W'(COUNT_MAX);
        else                           st_d.cnt = COUNT_W'(sum);
        st_d.op = (st_d.cnt >= COUNT_W'(OP_THRESH));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o   = st_q.cnt;
    assign operate_o = st_q.op;

    p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= COUNT_W'(COUNT_MAX));

    p_operate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.op == (st_q.cnt >= COUNT_W'(OP_THRESH)));

    p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i == '0 && dec_i == '0) |=> $stable(st_q.cnt));

    p_floor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt == '0 && inc_i == '0) |=> st_q.cnt == '0);

endmodule

// File: rtl/pdc_comparator.sv
module pdc_comparator
    import pdc_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 1_000_000,
    parameter int unsigned DEAD_MS   = 20,
    parameter int unsigned COUNT_MAX = 16,
    parameter int unsigned OP_THRESH = 8,
    localparam int unsigned COUNT_W  = $clog2(COUNT_MAX + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sig_a_i,
    input  logic               sig_b_i,
    input  logic               volt_ok_i,
    input  logic               curr_ok_i,
    output logic [COUNT_W-1:0] count_o,
    output logic               operate_o,
    output logic               pole_dead_o
);

    logic [NUM_SIG-1:0] edges;
    logic               coincide;
    logic               dead;
    step_t              n_edges, inc, dec;

    pdc_edge_sense i_edge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sig_i      ({sig_b_i, sig_a_i}),
        .edge_o     (edges),
        .coincide_o (coincide)
    );

    pdc_dead_timer #(
        .CLK_HZ  (CLK_HZ),
        .DEAD_MS (DEAD_MS)
    ) i_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .volt_ok_i (volt_ok_i),
        .curr_ok_i (curr_ok_i),
        .dead_o    (dead)
    );

    // steering: inhibit turns every transition into a down count
    always_comb begin
        n_edges = count_ones(edges);
        inc     = '0;
        dec     = '0;
        if (dead)          dec = n_edges;
        else if (coincide) inc = n_edges;
        else               dec = n_edges;
    end

    pdc_updown #(
        .COUNT_MAX (COUNT_MAX),
        .OP_THRESH (OP_THRESH)
    ) i_count (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_i     (inc),
        .dec_i     (dec),
        .count_o   (count_o),
        .operate_o (operate_o)
    );

    assign pole_dead_o = dead;

    p_inhibit_down_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dead && edges != '0 && count_o != '0) |=> count_o < $past(count_o));

    p_no_rise_dead_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dead |=> count_o <= $past(count_o));

endmodule

// File: tb/test_pdc_comparator.sv
module test_pdc_comparator;

    localparam int PERIOD    = 10;
    localparam int CLK_HZ    = 100_000;
    localparam int DEAD_MS   = 20;
    localparam int COUNT_MAX = 16;
    localparam int OP_THRESH = 8;
    localparam int DELAY     = CLK_HZ * DEAD_MS / 1000;
    localparam int CW        = $clog2(COUNT_MAX + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a = 1'b0, b = 1'b0, v = 1'b1, c = 1'b1;
    logic [CW-1:0] count;
    logic          operate, dead;

    typedef struct {
        int    cnt;
        bit    op;
        bit    dd;
        string tag;
    } item_t;

    item_t q[$];
    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;

    // reference model state
    int m_cnt = 0, m_tmr = 0;
    bit m_dead = 0, m_a = 0, m_b = 0;

    always #(PERIOD / 2) clk = ~clk;

    pdc_comparator #(
        .CLK_HZ    (CLK_HZ),
        .DEAD_MS   (DEAD_MS),
        .COUNT_MAX (COUNT_MAX),
        .OP_THRESH (OP_THRESH)
    ) i_pdc_comparator (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sig_a_i     (a),
        .sig_b_i     (b),
        .volt_ok_i   (v),
        .curr_ok_i   (c),
        .count_o     (count),
        .operate_o   (operate),
        .pole_dead_o (dead)
    );

    task automatic drive(input bit na, input bit nb, input bit nv, input bit nc,
                         input string tag);
        int    ne;
        item_t it;
        @(negedge clk);
        a = na; b = nb; v = nv; c = nc;
        @(posedge clk);
        #1;
        ne = int'(na != m_a) + int'(nb != m_b);
        if (m_dead || na != nb) m_cnt = (m_cnt - ne < 0) ? 0 : m_cnt - ne;
        else                    m_cnt = (m_cnt + ne > COUNT_MAX) ? COUNT_MAX : m_cnt + ne;
        m_a = na; m_b = nb;
        if (nv || nc) begin
            m_tmr = 0; m_dead = 0;
        end else if (m_tmr == DELAY - 1) begin
            m_dead = 1;
        end else begin
            m_tmr++;
        end
        it.cnt = m_cnt; it.op = (m_cnt >= OP_THRESH); it.dd = m_dead; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compare half a period after the outputs settle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_cmp++;
            if (int'(count) != it.cnt || operate != it.op || dead != it.dd) begin
                n_bad++;
                $display("FAIL %s: got cnt=%0d op=%0b dead=%0b, expected cnt=%0d op=%0b dead=%0b",
                         it.tag, count, operate, dead, it.cnt, it.op, it.dd);
            end
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #(PERIOD * 3);
        n_cmp++;
        if (count != '0 || operate || dead) begin
            n_bad++;
            $display("FAIL R1: got cnt=%0d op=%0b dead=%0b, expected 0 0 0", count, operate, dead);
        end
        @(negedge clk);
        rst_n = 1'b1;
        drive(0, 0, 1, 1, "R1");
        // R6: down step at zero
        drive(1, 0, 1, 1, "R6");
        // R2: single coincident transition
        drive(1, 1, 1, 1, "R2");
        // R3: single non-coincident transition
        drive(0, 1, 1, 1, "R3");
        drive(0, 0, 1, 1, "R2");
        // R4: simultaneous transitions count twice
        for (int i = 0; i < 10; i++) begin
            drive(!m_a, !m_b, 1, 1, "R4");
            drive(m_a, m_b, 1, 1, "R7");
        end
        // R5: saturation at maximum
        drive(1, 1, 1, 1, "R5");
        drive(0, 0, 1, 1, "R5");
        // R11: hold with no transitions
        for (int i = 0; i < 5; i++) drive(0, 0, 1, 1, "R11");
        // R4: simultaneous non-coincident pair
        drive(1, 0, 1, 1, "R4");
        drive(0, 1, 1, 1, "R4");
        // R9: one flag alone never sets pole-dead
        for (int i = 0; i < DELAY + 20; i++) drive(0, 1, 0, 1, "R9");
        for (int i = 0; i < DELAY + 20; i++) drive(0, 1, 1, 0, "R9");
        // R9: partial dead window then flag returns
        for (int i = 0; i < DELAY / 2; i++) drive(0, 1, 0, 0, "R8");
        drive(0, 1, 0, 1, "R9");
        // R7: climb back above threshold
        for (int i = 0; i < 8; i++) begin
            drive(1, 1, 1, 1, "R7");
            drive(0, 0, 1, 1, "R7");
        end
        // R8: exact rise of pole-dead
        for (int i = 0; i < DELAY + 3; i++) drive(0, 0, 0, 0, "R8");
        // R10: inhibited drain, coincident and single transitions
        drive(1, 1, 0, 0, "R10");
        drive(1, 0, 0, 0, "R10");
        drive(1, 1, 0, 0, "R10");
        for (int i = 0; i < 8; i++) drive(!m_a, !m_b, 0, 0, "R10");
        drive(0, 0, 0, 0, "R6");
        // R9: flag return clears pole-dead at once
        drive(0, 0, 1, 0, "R9");
        drive(1, 1, 1, 0, "R2");
        drive(1, 1, 1, 1, "R11");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule